// File: doc/BRIEF.md
# Selectable-Insertion Recency Stack for One Cache Set

This block holds the recency order of the ways of one set in a set-associative cache and names the way to replace on a miss. Each way carries a rank, where rank 0 is the most recently used (MRU) position and rank `NUM_WAYS-1` is the least recently used (LRU) position. A hit promotes the referenced way to MRU. On a miss, the victim is always the LRU way. The incoming line that refills the victim way is then placed according to a mode input.

The three insertion choices are as follows. The first is the classic choice, which places every fill at MRU. The second is LRU insertion, which leaves the fill at the LRU position so that a line that is never reused does not push out the lines that are reused. The third is a bimodal choice, which usually inserts at LRU and inserts at MRU about once in 32 fills. A free-running linear feedback shift register (LFSR) inside the block makes the bimodal choice. The tag and data arrays sit outside the block. The surrounding cache reports hit or miss and the hit way, and it uses `victim_way` to choose which way to refill.

Top module: `recency_stack_ctrl`

## Requirements
- R1: Reset gives way i the rank i. At every cycle, the ranks of all ways form a permutation of 0..NUM_WAYS-1. Way i's rank appears on `rank_o[i*WAY_W +: WAY_W]`.
- R2: `victim_way` always names the way whose rank is NUM_WAYS-1. It follows the registered order combinationally.
- R3: Take an access (`acc_valid`=1) with `acc_hit`=1 in any mode, and let r be the old rank of `acc_way`. One clock later, `acc_way` has rank 0, every way whose old rank was below r gains 1, and every other way keeps its rank.
- R4: With `mode`=2'b00, a miss gives the victim way rank 0 and adds 1 to the rank of every other way.
- R5: With `mode`=2'b01, a miss leaves every rank unchanged, so the filled way stays at the LRU position.
- R6: In `mode`=2'b01, a filled line leaves the LRU position only through a later hit that references it.
- R7: With `mode`=2'b10 or 2'b11, a miss acts as in R4 when the low 5 bits of the LFSR are all zero in the access cycle. Otherwise it acts as in R5.
- R8: The LFSR is a 16-bit Fibonacci register with the value 16'hACE1 at reset. Each clock, it shifts left and brings in the XOR of bits 15, 13, 12 and 10 as the new bit 0. It advances on every clock after reset, whether or not an access is made.
- R9: While `acc_valid`=0, the order is unchanged, whatever the values on `acc_hit`, `acc_way` and `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe for this set |
| acc_hit | input | 1 | The access hit (1) or missed (0) |
| acc_way | input | WAY_W | Way referenced by a hit |
| mode | input | 2 | Insertion choice: 00 MRU, 01 LRU, 10/11 bimodal |
| victim_way | output | WAY_W | Way to refill on a miss (current LRU way) |
| rank_o | output | NUM_WAYS*WAY_W | Rank of each way, way i in slice i |

## Verification
The bimodal MRU insertion is the hardest case to reach from the ports. It happens only in a cycle where the internal LFSR has five low zero bits, and that occurs about once in 32 cycles on a sequence the ports cannot steer. The bench keeps its own arithmetic model of the LFSR, which starts from the reset seed and steps every clock. It then issues a long run of bimodal misses, about 640 accesses, so that many such cycles are crossed. It compares the full rank vector after each miss and counts the MRU insertions that occur against the number the model predicts.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    typedef enum logic [1:0] {
        INS_AT_MRU  = 2'b00,
        INS_AT_LRU  = 2'b01,
        INS_BIMODAL = 2'b10,
        INS_BIM_ALT = 2'b11
    } ins_mode_e;

    localparam int unsigned LFSR_WIDTH   = 16;
    localparam logic [15:0] LFSR_SEED    = 16'hACE1;
    localparam logic [15:0] LFSR_TAPS    = 16'hB400;
    localparam int unsigned THROTTLE_LOG = 5;
endpackage

// File: rtl/rstk_lfsr.sv
module rstk_lfsr #(
    parameter int unsigned       W    = 16,
    parameter logic [W-1:0]      SEED = '1,
    parameter logic [W-1:0]      TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;
endmodule

// File: rtl/rstk_victim_find.sv
module rstk_victim_find #(
    parameter int unsigned NUM_WAYS = 16,
    parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WAY_W-1:0] rank_i,
    output logic [WAY_W-1:0]          victim_o
);
    localparam logic [WAY_W-1:0] LRU_RANK = WAY_W'(NUM_WAYS - 1);

    logic [NUM_WAYS-1:0] is_lru;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign is_lru[g] = (rank_i[g*WAY_W +: WAY_W] == LRU_RANK);
    end

    always_comb begin
        victim_o = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (is_lru[i]) victim_o = WAY_W'(i);
        end
    end
endmodule

// File: rtl/rstk_rank_update.sv
module rstk_rank_update #(
    parameter int unsigned NUM_WAYS = 16,
    parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WAY_W-1:0] rank_i,
    input  logic                      promote_i,
    input  logic [WAY_W-1:0]          pivot_i,
    output logic [NUM_WAYS*WAY_W-1:0] rank_o
);
    logic [WAY_W-1:0] pivot_rank;

    always_comb begin
        pivot_rank = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (pivot_i == WAY_W'(i)) pivot_rank = rank_i[i*WAY_W +: WAY_W];
        end
    end

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        logic [WAY_W-1:0] cur;
        assign cur = rank_i[g*WAY_W +: WAY_W];
        always_comb begin
            if (!promote_i)                   rank_o[g*WAY_W +: WAY_W] = cur;
            else if (pivot_i == WAY_W'(g))    rank_o[g*WAY_W +: WAY_W] = '0;
            else if (cur < pivot_rank)        rank_o[g*WAY_W +: WAY_W] = cur + 1'b1;
            else                              rank_o[g*WAY_W +: WAY_W] = cur;
        end
    end
endmodule

// File: rtl/recency_stack_ctrl.sv
module recency_stack_ctrl
    import rstk_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 16,
    parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_hit,
    input  logic [WAY_W-1:0]          acc_way,
    input  logic [1:0]                mode,
    output logic [WAY_W-1:0]          victim_way,
    output logic [NUM_WAYS*WAY_W-1:0] rank_o
);
    localparam int unsigned RANK_BITS = NUM_WAYS * WAY_W;

    typedef struct packed {
        logic [RANK_BITS-1:0] rank;
    } state_t;

    state_t                state_d, state_q;
    logic [LFSR_WIDTH-1:0] lfsr_val;
    logic                  throttle_hit;
    logic                  fill_mru;
    logic                  promote;
    logic [WAY_W-1:0]      pivot;
    logic [RANK_BITS-1:0]  rank_next;

    rstk_lfsr #(
        .W   (LFSR_WIDTH),
        .SEED(LFSR_SEED),
        .TAPS(LFSR_TAPS)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_o(lfsr_val)
    );

    rstk_victim_find #(
        .NUM_WAYS(NUM_WAYS),
        .WAY_W   (WAY_W)
    ) u_victim (
        .rank_i  (state_q.rank),
        .victim_o(victim_way)
    );

    always_comb begin
        throttle_hit = (lfsr_val[THROTTLE_LOG-1:0] == '0);
        unique case (ins_mode_e'(mode))
            INS_AT_MRU:  fill_mru = 1'b1;
            INS_AT_LRU:  fill_mru = 1'b0;
            INS_BIMODAL,
            INS_BIM_ALT: fill_mru = throttle_hit;
            default:     fill_mru = 1'b0;
        endcase
        promote = acc_valid && (acc_hit || fill_mru);
        pivot   = acc_hit ? acc_way : victim_way;
    end

    rstk_rank_update #(
        .NUM_WAYS(NUM_WAYS),
        .WAY_W   (WAY_W)
    ) u_update (
        .rank_i   (state_q.rank),
        .promote_i(promote),
        .pivot_i  (pivot),
        .rank_o   (rank_next)
    );

    always_comb begin
        state_d      = state_q;
        state_d.rank = rank_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                state_q.rank[i*WAY_W +: WAY_W] <= WAY_W'(i);
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign rank_o = state_q.rank;
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
    parameter int unsigned NUM_WAYS = 16,
    parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic                      acc_hit,
    input logic [WAY_W-1:0]          acc_way,
    input logic [1:0]                mode,
    input logic [WAY_W-1:0]          victim_way,
    input logic [NUM_WAYS*WAY_W-1:0] rank_o
);
    function automatic logic [WAY_W-1:0] rank_of(input logic [NUM_WAYS*WAY_W-1:0] flat,
                                                 input logic [WAY_W-1:0] way);
        return flat[int'(way)*WAY_W +: WAY_W];
    endfunction

    for (genvar k = 0; k < NUM_WAYS; k++) begin : g_perm
        logic [NUM_WAYS-1:0] holders;
        always_comb begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                holders[i] = (rank_o[i*WAY_W +: WAY_W] == WAY_W'(k));
            end
        end
        AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(holders)); // R1
    end

    AST_VICTIM_LRU: assert property (@(posedge clk) disable iff (!rst_n)
        rank_of(rank_o, victim_way) == WAY_W'(NUM_WAYS - 1)); // R2

    AST_HIT_TO_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_hit |=> rank_of(rank_o, $past(acc_way)) == '0); // R3

    AST_MRU_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_hit && mode == 2'b00 |=> rank_of(rank_o, $past(victim_way)) == '0); // R4

    AST_LRU_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_hit && mode == 2'b01 |=> $stable(rank_o)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(rank_o)); // R9
endmodule

bind recency_stack_ctrl rstk_checker #(
    .NUM_WAYS(NUM_WAYS),
    .WAY_W   (WAY_W)
) u_rstk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_hit   (acc_hit),
    .acc_way   (acc_way),
    .mode      (mode),
    .victim_way(victim_way),
    .rank_o    (rank_o)
);

// File: tb/recency_stack_ctrl_bench.sv
module recency_stack_ctrl_bench;
    localparam int NW = 16;
    localparam int WW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_hit = 1'b0;
    logic [WW-1:0]   acc_way = '0;
    logic [1:0]      mode = 2'b00;
    logic [WW-1:0]   victim_way;
    logic [NW*WW-1:0] rank_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int          m_rank [NW];
    logic [15:0] m_lfsr;
    int          exp_mru_fills = 0;
    int          obs_mru_fills = 0;

    always #5 clk = ~clk;

    recency_stack_ctrl u_recency_stack_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .mode(mode), .victim_way(victim_way), .rank_o(rank_o)
    );

    // R8: bench model of the throttle register
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NW*WW-1:0] model_flat();
        logic [NW*WW-1:0] f;
        for (int i = 0; i < NW; i++) f[i*WW +: WW] = WW'(m_rank[i]);
        return f;
    endfunction

    function automatic int model_lru();
        int v = 0;
        for (int i = 0; i < NW; i++) if (m_rank[i] == NW - 1) v = i;
        return v;
    endfunction

    task automatic promote(input int w);
        int r = m_rank[w];
        for (int i = 0; i < NW; i++) if (m_rank[i] < r) m_rank[i]++;
        m_rank[w] = 0;
    endtask

    task automatic access(input bit v, input bit h, input int w, input logic [1:0] md,
                          input string req);
        int  vic;
        bit  to_mru;
        @(negedge clk);
        acc_valid = v; acc_hit = h; acc_way = WW'(w); mode = md;
        vic = model_lru();
        check("R2", 64'(victim_way), 64'(vic));
        if (v) begin
            if (h) promote(w);
            else begin
                case (md)
                    2'b00:   to_mru = 1'b1;
                    2'b01:   to_mru = 1'b0;
                    default: to_mru = (m_lfsr[4:0] == 5'd0);
                endcase
                if (md[1]) exp_mru_fills += int'(to_mru);
                if (to_mru) promote(vic);
            end
        end
        @(posedge clk);
        #1;
        if (v && !h && md[1] && rank_o[vic*WW +: WW] == 0) obs_mru_fills++;
        check(req, 64'(rank_o), 64'(model_flat()));
        acc_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) m_rank[i] = i;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 64'(rank_o), 64'(model_flat()));
        check("R2 reset", 64'(victim_way), 64'(NW - 1));
        rst_n = 1'b1;

        // R3: hit sweeps in several orders
        for (int w = 0; w < NW; w++) access(1, 1, w, 2'b00, "R3 fwd");
        for (int w = NW - 1; w >= 0; w--) access(1, 1, w, 2'b01, "R3 rev");
        for (int k = 0; k < 40; k++) access(1, 1, (k * 7 + 3) % NW, 2'(k % 4), "R3 mix");
        access(1, 1, model_lru(), 2'b10, "R3 lru hit");
        access(1, 1, 5, 2'b00, "R3 repeat");
        access(1, 1, 5, 2'b00, "R3 mru hit");

        // R4: classic fills
        for (int k = 0; k < 20; k++) access(1, 0, 0, 2'b00, "R4");

        // R5 / R6: LRU insertion then reuse of the filled way
        for (int k = 0; k < 6; k++) access(1, 0, 0, 2'b01, "R5");
        begin
            int filled = model_lru();
            access(1, 1, filled, 2'b01, "R6");
            check("R6 promoted", 64'(rank_o[filled*WW +: WW]), 64'd0);
        end

        // R9: strobe low, other inputs toggled
        for (int k = 0; k < 12; k++) access(0, k[0], k, 2'(k), "R9");

        // R7 / R8: long bimodal runs
        for (int k = 0; k < 640; k++) access(1, 0, 0, (k < 320) ? 2'b10 : 2'b11, "R7");
        for (int k = 0; k < 7; k++) access(0, 0, 0, 2'b10, "R8 idle");
        for (int k = 0; k < 64; k++) access(1, 0, 0, 2'b10, "R8");
        check("R7 mru fill count", 64'(obs_mru_fills), 64'(exp_mru_fills));
        n_chk++;
        if (exp_mru_fills == 0) begin
            n_bad++;
            $display("FAIL R7 no bimodal MRU fill reached actual=0 expected=>0");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule